// File: doc/BRIEF.md
# Interrupt Request and In-Service Tracker

This block keeps two pieces of state for a small interrupt controller. The first is a sticky pending bit for each internal source: three timers and two DMA channels. A pending bit is set when the source raises a request and is cleared by the acknowledge that the controller issues for that source. The second is an in-service bit for each of seven sources: the five internal ones and two external lines. An in-service bit is set when the processor takes that source's interrupt. Software clears it by writing the source's type code to an end-of-interrupt address.

The block combines the two sets of state into a per-source request vector for the arbiter that follows it. A source that is in service cannot raise a new request, so a handler cannot be interrupted by its own source. The one exception is a nested mode input: while it is high, the two external lines may interrupt their own handlers. Software reads both registers through a small address-decoded read port. Priority, vectoring and processor sequencing live elsewhere.

Top module: `irq_track`

## Requirements
- R1: After reset the pending register, the in-service register and `irq_o` are all zero.
- R2: The pending word read at address 0 places timer 0 at bit 0, DMA 0 at bit 2, DMA 1 at bit 3, timer 1 at bit 4 and timer 2 at bit 5. Bit 1 and bits 15 to 6 read as zero. Internal request index 0..4 maps to timer 0, DMA 0, DMA 1, timer 1 and timer 2.
- R3: A request sampled high at a clock edge sets its pending bit from that edge on. The bit stays set after the request drops, until it is acknowledged.
- R4: An acknowledge clears its pending bit at the next edge. When a request and an acknowledge for the same source arrive in the same cycle, the bit ends up set.
- R5: Writes to address 0 (pending) and address 1 (in-service) change neither register.
- R6: A take with source index 0..6 (internal 0..4, then external 0 and 1) sets that in-service bit at the next edge. The in-service word at address 1 places source index i at bit i. A take with index 7 does nothing.
- R7: A write to address 2 whose full 16-bit data equals a source index clears that in-service bit. Any other data value is ignored. A take and a clear for the same source in the same cycle leave the bit set.
- R8: For an internal source, `irq_o[i]` is its pending bit gated by the inverse of its in-service bit. For an external line, it is the live input gated the same way.
- R9: While `nest_mode_i` is high, the external lines bypass in-service masking. Internal sources stay masked.
- R10: A read of address 2 or 3 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| int_req_i | input | 5 | Internal request per source |
| int_ack_i | input | 5 | Acknowledge per internal source, clears pending |
| ext_req_i | input | 2 | External request lines |
| nest_mode_i | input | 1 | Nested mode: external lines ignore their in-service mask |
| take_i | input | 1 | An interrupt is being taken this cycle |
| take_src_i | input | 3 | Source index being taken |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address: 0 pending, 1 in-service, 2 end-of-interrupt |
| wr_data_i | input | 16 | Write data; at address 2 it is the type code |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | 16 | Read data |
| irq_o | output | 7 | Masked request per source index |

## Verification
The bench builds the tracker with its defaults: five internal sources, two external lines and a 16-bit data path. With these values every source index and the unused index 7 can be reached, and the random mix of end-of-interrupt data exercises both matching type codes and codes that fit no source. Directed steps cover the simultaneous request and acknowledge, the simultaneous take and clear, and both settings of the nested mode. Long random runs let the pending bits, in-service bits and external lines overlap in every combination.

// File: rtl/irq_track_pkg.sv
package irq_track_pkg;

    typedef enum logic [1:0] {
        RA_PEND  = 2'd0,
        RA_ISR   = 2'd1,
        RA_EOI   = 2'd2,
        RA_SPARE = 2'd3
    } reg_addr_e;

    // Bit position of internal source i in the pending word.
    // Index 0 sits at bit 0; bit 1 is left empty; the rest follow from bit 2.
    function automatic int pend_bit(input int i);
        return (i == 0) ? 0 : i + 1;
    endfunction

endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
    parameter int N_INT = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_INT-1:0] req_i,
    input  logic [N_INT-1:0] ack_i,
    output logic [N_INT-1:0] pend_o
);

    typedef struct packed {
        logic [N_INT-1:0] pend;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N_INT; i++) begin
            // a fresh request wins over a same-cycle acknowledge
            st_d.pend[i] = req_i[i] | (st_q.pend[i] & ~ack_i[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;

endmodule

// File: rtl/irq_isr_bank.sv
module irq_isr_bank #(
    parameter int N_SRC  = 7,
    parameter int DATA_W = 16,
    parameter int SRC_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_i,
    input  logic [SRC_W-1:0]  take_src_i,
    input  logic              eoi_we_i,
    input  logic [DATA_W-1:0] eoi_data_i,
    output logic [N_SRC-1:0]  isr_o
);

    typedef struct packed {
        logic [N_SRC-1:0] isr;
    } state_t;

    state_t st_d, st_q;
    logic [N_SRC-1:0] set_d, clr_d;

    always_comb begin
        st_d  = st_q;
        set_d = '0;
        clr_d = '0;
        for (int j = 0; j < N_SRC; j++) begin
            set_d[j] = take_i && (take_src_i == SRC_W'(j));
            clr_d[j] = eoi_we_i && (eoi_data_i == DATA_W'(j));
            // taking the source again in the clearing cycle keeps it in service
            st_d.isr[j] = set_d[j] | (st_q.isr[j] & ~clr_d[j]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign isr_o = st_q.isr;

endmodule

// File: rtl/irq_fwd.sv
module irq_fwd #(
    parameter int N_INT = 5,
    parameter int N_EXT = 2
) (
    input  logic [N_INT-1:0]       pend_i,
    input  logic [N_EXT-1:0]       ext_i,
    input  logic [N_INT+N_EXT-1:0] isr_i,
    input  logic                   nest_i,
    output logic [N_INT+N_EXT-1:0] irq_o
);

    for (genvar i = 0; i < N_INT; i++) begin : g_int
        assign irq_o[i] = pend_i[i] & ~isr_i[i];
    end

    for (genvar k = 0; k < N_EXT; k++) begin : g_ext
        assign irq_o[N_INT+k] = ext_i[k] & (~isr_i[N_INT+k] | nest_i);
    end

endmodule

// File: rtl/irq_rd_mux.sv
module irq_rd_mux
    import irq_track_pkg::*;
#(
    parameter int N_INT  = 5,
    parameter int N_SRC  = 7,
    parameter int DATA_W = 16
) (
    input  logic [1:0]        addr_i,
    input  logic [N_INT-1:0]  pend_i,
    input  logic [N_SRC-1:0]  isr_i,
    output logic [DATA_W-1:0] data_o
);

    logic [DATA_W-1:0] pend_word, isr_word;

    always_comb begin
        pend_word = '0;
        for (int i = 0; i < N_INT; i++) begin
            pend_word[pend_bit(i)] = pend_i[i];
        end
        isr_word = '0;
        isr_word[N_SRC-1:0] = isr_i;
        case (addr_i)
            RA_PEND: data_o = pend_word;
            RA_ISR:  data_o = isr_word;
            default: data_o = '0;
        endcase
    end

endmodule

// File: rtl/irq_track.sv
module irq_track
    import irq_track_pkg::*;
#(
    parameter  int N_INT  = 5,
    parameter  int N_EXT  = 2,
    parameter  int DATA_W = 16,
    localparam int N_SRC  = N_INT + N_EXT,
    localparam int SRC_W  = $clog2(N_SRC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_INT-1:0]  int_req_i,
    input  logic [N_INT-1:0]  int_ack_i,
    input  logic [N_EXT-1:0]  ext_req_i,
    input  logic              nest_mode_i,
    input  logic              take_i,
    input  logic [SRC_W-1:0]  take_src_i,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [1:0]        rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic [N_SRC-1:0]  irq_o
);

    logic [N_INT-1:0] pend_q;
    logic [N_SRC-1:0] isr_q;
    logic             eoi_we;

    // pending and in-service addresses are read-only; only the EOI address acts
    assign eoi_we = wr_en_i && (wr_addr_i == RA_EOI);

    irq_pend_bank #(.N_INT(N_INT)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (int_req_i),
        .ack_i  (int_ack_i),
        .pend_o (pend_q)
    );

    irq_isr_bank #(.N_SRC(N_SRC), .DATA_W(DATA_W), .SRC_W(SRC_W)) u_isr (
        .clk        (clk),
        .rst_n      (rst_n),
        .take_i     (take_i),
        .take_src_i (take_src_i),
        .eoi_we_i   (eoi_we),
        .eoi_data_i (wr_data_i),
        .isr_o      (isr_q)
    );

    irq_fwd #(.N_INT(N_INT), .N_EXT(N_EXT)) u_fwd (
        .pend_i (pend_q),
        .ext_i  (ext_req_i),
        .isr_i  (isr_q),
        .nest_i (nest_mode_i),
        .irq_o  (irq_o)
    );

    irq_rd_mux #(.N_INT(N_INT), .N_SRC(N_SRC), .DATA_W(DATA_W)) u_rd (
        .addr_i (rd_addr_i),
        .pend_i (pend_q),
        .isr_i  (isr_q),
        .data_o (rd_data_o)
    );

endmodule

// File: rtl/irq_track_chk.sv
module irq_track_chk #(
    parameter  int N_INT  = 5,
    parameter  int N_EXT  = 2,
    parameter  int DATA_W = 16,
    localparam int N_SRC  = N_INT + N_EXT,
    localparam int SRC_W  = $clog2(N_SRC)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_INT-1:0]  int_req_i,
    input logic [N_INT-1:0]  int_ack_i,
    input logic              nest_mode_i,
    input logic              take_i,
    input logic [SRC_W-1:0]  take_src_i,
    input logic              wr_en_i,
    input logic [1:0]        wr_addr_i,
    input logic [DATA_W-1:0] wr_data_i,
    input logic [1:0]        rd_addr_i,
    input logic [DATA_W-1:0] rd_data_o,
    input logic [N_SRC-1:0]  irq_o,
    input logic [N_INT-1:0]  pend_q,
    input logic [N_SRC-1:0]  isr_q
);

    for (genvar i = 0; i < N_INT; i++) begin : g_int
        AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
            int_req_i[i] |=> pend_q[i]); // R3
        AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            pend_q[i] && !int_ack_i[i] |=> pend_q[i]); // R3
        AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            int_ack_i[i] && !int_req_i[i] |=> !pend_q[i]); // R4
        AST_INT_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
            isr_q[i] |-> !irq_o[i]); // R8
    end

    for (genvar k = 0; k < N_EXT; k++) begin : g_ext
        AST_EXT_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
            isr_q[N_INT+k] && !nest_mode_i |-> !irq_o[N_INT+k]); // R9
    end

    for (genvar j = 0; j < N_SRC; j++) begin : g_src
        AST_TAKE_SET: assert property (@(posedge clk) disable iff (!rst_n)
            take_i && take_src_i == SRC_W'(j) |=> isr_q[j]); // R6
        AST_ISR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            isr_q[j] && !(wr_en_i && wr_addr_i == 2'd2 && wr_data_i == DATA_W'(j))
            |=> isr_q[j]); // R7
    end

    AST_PEND_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_addr_i == 2'd0 |-> rd_data_o[1] == 1'b0 &&
        (rd_data_o >> (N_INT + 1)) == DATA_W'(0)); // R2

endmodule

bind irq_track irq_track_chk #(.N_INT(N_INT), .N_EXT(N_EXT), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .int_req_i   (int_req_i),
    .int_ack_i   (int_ack_i),
    .nest_mode_i (nest_mode_i),
    .take_i      (take_i),
    .take_src_i  (take_src_i),
    .wr_en_i     (wr_en_i),
    .wr_addr_i   (wr_addr_i),
    .wr_data_i   (wr_data_i),
    .rd_addr_i   (rd_addr_i),
    .rd_data_o   (rd_data_o),
    .irq_o       (irq_o),
    .pend_q      (pend_q),
    .isr_q       (isr_q)
);

// File: tb/tb_irq_track.sv
module tb_irq_track;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [4:0]  int_req_i, int_ack_i;
    logic [1:0]  ext_req_i;
    logic        nest_mode_i, take_i, wr_en_i;
    logic [2:0]  take_src_i;
    logic [1:0]  wr_addr_i, rd_addr_i;
    logic [15:0] wr_data_i, rd_data_o;
    logic [6:0]  irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [4:0] p_m;
    logic [6:0] s_m;

    always #10 clk = ~clk;

    irq_track dut (
        .clk(clk), .rst_n(rst_n), .int_req_i(int_req_i), .int_ack_i(int_ack_i),
        .ext_req_i(ext_req_i), .nest_mode_i(nest_mode_i), .take_i(take_i),
        .take_src_i(take_src_i), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
        .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
        .irq_o(irq_o)
    );

    function automatic logic [15:0] rd_exp(input logic [1:0] a, input logic [4:0] p,
                                           input logic [6:0] s);
        logic [15:0] w = '0;
        if (a == 2'd0) begin
            w[0] = p[0];
            for (int i = 1; i < 5; i++) w[i+1] = p[i];
        end else if (a == 2'd1) begin
            w[6:0] = s;
        end
        return w;
    endfunction

    function automatic logic [6:0] irq_exp(input logic [4:0] p, input logic [6:0] s,
                                           input logic [1:0] e, input logic n);
        logic [6:0] r;
        for (int i = 0; i < 5; i++) r[i] = p[i] & ~s[i];
        for (int k = 0; k < 2; k++) r[5+k] = e[k] & (~s[5+k] | n);
        return r;
    endfunction

    function automatic logic [6:0] isr_next(input logic [6:0] s);
        logic [6:0] r = s;
        for (int j = 0; j < 7; j++) begin
            if (wr_en_i && wr_addr_i == 2'd2 && wr_data_i == 16'(j)) r[j] = 1'b0;
            if (take_i && take_src_i == 3'(j)) r[j] = 1'b1;
        end
        return r;
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        int_req_i = '0; int_ack_i = '0; take_i = 1'b0; take_src_i = '0;
        wr_en_i = 1'b0; wr_addr_i = '0; wr_data_i = '0;
    endtask

    // check outputs against the model, then clock and advance the model
    task automatic tick();
        #1;
        chk(nest_mode_i ? "R9 irq" : "R8 irq", 16'(irq_o), 16'(irq_exp(p_m, s_m, ext_req_i, nest_mode_i)));
        chk(rd_addr_i == 2'd0 ? "R2 pend read" : rd_addr_i == 2'd1 ? "R6 isr read" : "R10 spare read",
            rd_data_o, rd_exp(rd_addr_i, p_m, s_m));
        @(posedge clk);
        s_m = isr_next(s_m);
        p_m = int_req_i | (p_m & ~int_ack_i);
        @(negedge clk);
    endtask

    task automatic peek(input string tag, input logic [1:0] a, input logic [15:0] exp);
        rd_addr_i = a;
        #1;
        chk(tag, rd_data_o, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5A17));
        idle();
        ext_req_i = '0; nest_mode_i = 1'b0; rd_addr_i = '0;
        p_m = '0; s_m = '0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        peek("R1 pend", 2'd0, 16'h0000);
        peek("R1 isr", 2'd1, 16'h0000);
        chk("R1 irq", 16'(irq_o), 16'h0000);

        // R2/R3: all internal requests for one cycle, then released
        int_req_i = 5'b11111; tick(); idle(); tick();
        peek("R2 R3 pend layout sticky", 2'd0, 16'h003D);

        // R4: same-cycle request and acknowledge on source 0 keeps it set
        int_ack_i = 5'b11111; int_req_i = 5'b00001; tick(); idle();
        peek("R4 req beats ack", 2'd0, 16'h0001);
        int_ack_i = 5'b00001; tick(); idle();
        peek("R4 ack clears", 2'd0, 16'h0000);

        // R5: writes to read-only addresses
        int_req_i = 5'b00010; tick(); idle();
        wr_en_i = 1'b1; wr_addr_i = 2'd0; wr_data_i = 16'hFFFF; tick();
        wr_addr_i = 2'd1; tick(); idle();
        peek("R5 pend unchanged", 2'd0, 16'h0004);
        peek("R5 isr unchanged", 2'd1, 16'h0000);

        // R6/R7/R8: take DMA 0, mismatched EOIs, then a matching one
        take_i = 1'b1; take_src_i = 3'd1; tick(); idle();
        peek("R6 take sets", 2'd1, 16'h0002);
        chk("R8 masked", 16'(irq_o), 16'h0000);
        wr_en_i = 1'b1; wr_addr_i = 2'd2; wr_data_i = 16'h0101; tick();
        wr_data_i = 16'h0007; tick(); idle();
        peek("R7 bad type ignored", 2'd1, 16'h0002);
        wr_en_i = 1'b1; wr_addr_i = 2'd2; wr_data_i = 16'h0001; tick(); idle();
        peek("R7 eoi clears", 2'd1, 16'h0000);
        chk("R8 unmasked", 16'(irq_o), 16'h0002);

        // R9: external 0 in service, nested mode off then on
        take_i = 1'b1; take_src_i = 3'd5; tick(); idle();
        ext_req_i = 2'b11; #1;
        chk("R9 ext masked", 16'(irq_o), 16'h0042);
        nest_mode_i = 1'b1; #1;
        chk("R9 ext bypass", 16'(irq_o), 16'h0062);
        take_i = 1'b1; take_src_i = 3'd1; tick(); idle(); #1;
        chk("R9 internal still masked", 16'(irq_o), 16'h0060);

        // R7: take and EOI on the same source together; R6: index 7 ignored
        take_i = 1'b1; take_src_i = 3'd4; wr_en_i = 1'b1; wr_addr_i = 2'd2;
        wr_data_i = 16'h0004; tick(); idle();
        peek("R7 take beats eoi", 2'd1, 16'h0032);
        take_i = 1'b1; take_src_i = 3'd7; tick(); idle();
        peek("R6 index 7 ignored", 2'd1, 16'h0032);

        // R10: spare addresses
        peek("R10 addr2", 2'd2, 16'h0000);
        peek("R10 addr3", 2'd3, 16'h0000);

        // constrained random phase
        for (int c = 0; c < 4000; c++) begin
            int_req_i  = 5'($urandom) & 5'($urandom);
            int_ack_i  = 5'($urandom) & 5'($urandom);
            take_i     = ($urandom % 3) == 0;
            take_src_i = 3'($urandom);
            wr_en_i    = ($urandom % 3) == 0;
            wr_addr_i  = (($urandom % 4) == 0) ? 2'($urandom) : 2'd2;
            wr_data_i  = (($urandom % 5) == 0) ? 16'($urandom) : 16'($urandom % 8);
            ext_req_i  = 2'($urandom);
            if (($urandom % 16) == 0) nest_mode_i = ~nest_mode_i;
            rd_addr_i  = 2'($urandom);
            tick();
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule